// File: doc/BRIEF.md
# Offset-Selecting Branch Target Buffer

This block predicts where a taken branch goes before the fetched bytes are decoded. The fetch unit presents the start address of a 16-byte block, the low four bits of which give the byte at which fetch resumes. A 4-way, 512-set array of partial-tag entries is searched. Each entry records the byte position of a branch inside its block. A way is a candidate only if the branch it holds lies at or after the fetch position. If several ways qualify, the entry with the nearest such branch wins. The result gives a hit flag, the target, a branch kind and the chosen byte position. It appears in the cycle after the address is presented.

Resolved taken branches are written back through an update port. An update refreshes a matching entry in place. Otherwise it takes a free way, or evicts the least recently used way of its set. Tags are partial, so an instruction that is not a branch can alias onto an entry. When decode reports such a false hit, a separate port clears every way of the affected set.

Top module: `btb_offset_top`

## Requirements
- R1: An address splits into a byte position (bits [3:0]), a set number (bits [12:4]) and a 9-bit partial tag (bits [21:13]). A lookup can only hit an entry written with the same set and tag.
- R2: A lookup presented in one cycle produces its result in the next cycle. When no lookup was presented, the hit flag is 0 and the target, kind and position outputs are all zero.
- R3: After reset the array is empty and no lookup hits.
- R4: A way is a candidate only if it is valid, its tag matches and its stored byte position is greater than or equal to the fetch byte position. A branch stored below the fetch position is not returned.
- R5: When several ways are candidates, the reported entry is the one with the smallest stored byte position.
- R6: An update whose set, tag and byte position equal those of a valid way rewrites that way's target and kind and allocates no second copy.
- R7: A new entry takes an invalid way when the set has one. Otherwise it evicts the least recently used way. Both a lookup hit and an update make the touched way the most recent.
- R8: A false-hit report for a set clears all ways of that set. Other sets are untouched.
- R9: An update and a lookup to the same set in the same cycle act as if the update came first. The lookup sees the new target and kind.
- R10: The 2-bit branch kind written with an entry is returned with each hit on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 22 | Fetch address bits [21:0] |
| up_valid | input | 1 | Write a resolved taken branch |
| up_addr | input | 22 | Branch address bits [21:0] |
| up_target | input | 32 | Branch target |
| up_kind | input | 2 | Branch kind |
| bog_valid | input | 1 | False-hit report |
| bog_set | input | 9 | Set to clear |
| rs_hit | output | 1 | Prediction valid |
| rs_target | output | 32 | Predicted target |
| rs_kind | output | 2 | Kind of the chosen entry |
| rs_offset | output | 4 | Byte position of the chosen branch |

## Verification
The bound checker checks every cycle that the outputs stay idle with no lookup in flight. It also checks that a hit never reports a byte position below the fetch position, that a set cleared in the same cycle as a lookup gives a miss, and that a same-cycle update to the looked-up address is returned at once. The bench scenarios cover what no single-cycle property expresses. These are the choice of the nearest branch among several candidates, in-place refresh versus duplicate allocation, and the eviction order that lookup hits set up. They also cover tag and set mismatches and the survival of neighbouring sets after a clear.

// File: rtl/btb_pkg.sv
package btb_pkg;
   localparam int unsigned BTB_OFF_W  = 4;
   localparam int unsigned BTB_IDX_W  = 9;
   localparam int unsigned BTB_TAG_W  = 9;
   localparam int unsigned BTB_WAYS   = 4;
   localparam int unsigned BTB_TGT_W  = 32;
   localparam int unsigned BTB_KIND_W = 2;

   typedef enum logic [1:0] {
      BK_COND   = 2'd0,
      BK_DIRECT = 2'd1,
      BK_CALL   = 2'd2,
      BK_RETURN = 2'd3
   } btb_kind_e;
endpackage

// File: rtl/btb_age_touch.sv
module btb_age_touch #(
   parameter int unsigned WAYS  = 4,
   parameter int unsigned WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0][WAY_W-1:0] age_i,
   input  logic [WAY_W-1:0]           way_i,
   input  logic                       en_i,
   output logic [WAYS-1:0][WAY_W-1:0] age_o
);
   always_comb begin
      for (int i = 0; i < WAYS; i++) begin
         if (!en_i)
            age_o[i] = age_i[i];
         else if (WAY_W'(i) == way_i)
            age_o[i] = '0;
         else if (age_i[i] < age_i[way_i])
            age_o[i] = age_i[i] + 1'b1;
         else
            age_o[i] = age_i[i];
      end
   end
endmodule

// File: rtl/btb_pick.sv
module btb_pick #(
   parameter int unsigned WAYS  = 4,
   parameter int unsigned OFF_W = 4,
   parameter int unsigned WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]            cand_i,
   input  logic [WAYS-1:0][OFF_W-1:0] off_i,
   output logic                       hit_o,
   output logic [WAY_W-1:0]           way_o
);
   logic [OFF_W-1:0] best;

   always_comb begin
      hit_o = 1'b0;
      way_o = '0;
      best  = '1;
      for (int i = 0; i < WAYS; i++) begin
         if (cand_i[i] && (!hit_o || off_i[i] < best)) begin
            hit_o = 1'b1;
            way_o = WAY_W'(i);
            best  = off_i[i];
         end
      end
   end
endmodule

// File: rtl/btb_victim.sv
module btb_victim #(
   parameter int unsigned WAYS  = 4,
   parameter int unsigned WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]            match_i,
   input  logic [WAYS-1:0]            vld_i,
   input  logic [WAYS-1:0][WAY_W-1:0] age_i,
   output logic [WAY_W-1:0]           way_o
);
   logic found;

   always_comb begin
      found = 1'b0;
      way_o = '0;
      for (int i = 0; i < WAYS; i++)
         if (!found && match_i[i]) begin
            found = 1'b1;
            way_o = WAY_W'(i);
         end
      for (int i = 0; i < WAYS; i++)
         if (!found && !vld_i[i]) begin
            found = 1'b1;
            way_o = WAY_W'(i);
         end
      for (int i = 0; i < WAYS; i++)
         if (!found && age_i[i] == WAY_W'(WAYS-1)) begin
            found = 1'b1;
            way_o = WAY_W'(i);
         end
   end
endmodule

// File: rtl/btb_offset_top.sv
module btb_offset_top #(
   parameter int unsigned OFF_W  = btb_pkg::BTB_OFF_W,
   parameter int unsigned IDX_W  = btb_pkg::BTB_IDX_W,
   parameter int unsigned TAG_W  = btb_pkg::BTB_TAG_W,
   parameter int unsigned WAYS   = btb_pkg::BTB_WAYS,
   parameter int unsigned TGT_W  = btb_pkg::BTB_TGT_W,
   parameter int unsigned KIND_W = btb_pkg::BTB_KIND_W,
   localparam int unsigned TAG_LSB = OFF_W + IDX_W,
   localparam int unsigned USE_W   = TAG_LSB + TAG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [USE_W-1:0]  lk_addr,
   input  logic              up_valid,
   input  logic [USE_W-1:0]  up_addr,
   input  logic [TGT_W-1:0]  up_target,
   input  logic [KIND_W-1:0] up_kind,
   input  logic              bog_valid,
   input  logic [IDX_W-1:0]  bog_set,
   output logic              rs_hit,
   output logic [TGT_W-1:0]  rs_target,
   output logic [KIND_W-1:0] rs_kind,
   output logic [OFF_W-1:0]  rs_offset
);
   localparam int unsigned SETS  = 1 << IDX_W;
   localparam int unsigned WAY_W = $clog2(WAYS);

   initial begin
      assert (WAYS >= 2 && (1 << WAY_W) == WAYS)
         else $error("WAYS must be a power of two, at least 2");
      assert (OFF_W >= 1 && IDX_W >= 1 && TAG_W >= 1)
         else $error("address fields must be non-empty");
   end

   logic [WAYS-1:0]            vld_q [SETS];
   logic [WAYS-1:0][WAY_W-1:0] age_q [SETS];
   logic [TAG_W-1:0]           tag_q [SETS][WAYS];
   logic [OFF_W-1:0]           off_q [SETS][WAYS];
   logic [KIND_W-1:0]          kind_q [SETS][WAYS];
   logic [TGT_W-1:0]           tgt_q [SETS][WAYS];

   // lookup stage: capture the fetch address, read after this edge's writes
   logic             lk_q;
   logic [USE_W-1:0] lk_addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lk_q      <= 1'b0;
         lk_addr_q <= '0;
      end else begin
         lk_q <= lk_valid;
         if (lk_valid) lk_addr_q <= lk_addr;
      end
   end

   logic [IDX_W-1:0] lk_set, up_set;
   logic [OFF_W-1:0] lk_off, up_off;
   logic [TAG_W-1:0] lk_tag, up_tag;

   assign lk_off = lk_addr_q[OFF_W-1:0];
   assign lk_set = lk_addr_q[TAG_LSB-1:OFF_W];
   assign lk_tag = lk_addr_q[USE_W-1:TAG_LSB];
   assign up_off = up_addr[OFF_W-1:0];
   assign up_set = up_addr[TAG_LSB-1:OFF_W];
   assign up_tag = up_addr[USE_W-1:TAG_LSB];

   logic [WAYS-1:0]            cand, up_match;
   logic [WAYS-1:0][OFF_W-1:0] lk_offs;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign cand[w] = lk_q && vld_q[lk_set][w] && tag_q[lk_set][w] == lk_tag
                       && off_q[lk_set][w] >= lk_off;
      assign lk_offs[w]  = off_q[lk_set][w];
      assign up_match[w] = vld_q[up_set][w] && tag_q[up_set][w] == up_tag
                           && off_q[up_set][w] == up_off;
   end

   logic             hit;
   logic [WAY_W-1:0] hway, vway;

   btb_pick #(.WAYS(WAYS), .OFF_W(OFF_W)) pick_i (
      .cand_i(cand), .off_i(lk_offs), .hit_o(hit), .way_o(hway)
   );

   // recency: the lookup touch is applied before the update touch
   logic [WAYS-1:0][WAY_W-1:0] age_hit_new, age_up_base, age_up_new;

   btb_age_touch #(.WAYS(WAYS)) touch_lk_i (
      .age_i(age_q[lk_set]), .way_i(hway), .en_i(hit), .age_o(age_hit_new)
   );

   assign age_up_base = (hit && lk_set == up_set) ? age_hit_new : age_q[up_set];

   btb_victim #(.WAYS(WAYS)) victim_i (
      .match_i(up_match), .vld_i(vld_q[up_set]), .age_i(age_up_base), .way_o(vway)
   );

   btb_age_touch #(.WAYS(WAYS)) touch_up_i (
      .age_i(age_up_base), .way_i(vway), .en_i(1'b1), .age_o(age_up_new)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            vld_q[s] <= '0;
            for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
         end
      end else begin
         if (hit) age_q[lk_set] <= age_hit_new;
         if (bog_valid) vld_q[bog_set] <= '0;
         if (up_valid) begin
            vld_q[up_set][vway] <= 1'b1;
            age_q[up_set]       <= age_up_new;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (up_valid) begin
         tag_q[up_set][vway]  <= up_tag;
         off_q[up_set][vway]  <= up_off;
         kind_q[up_set][vway] <= up_kind;
         tgt_q[up_set][vway]  <= up_target;
      end
   end

   assign rs_hit    = hit;
   assign rs_target = hit ? tgt_q[lk_set][hway]  : '0;
   assign rs_kind   = hit ? kind_q[lk_set][hway] : '0;
   assign rs_offset = hit ? off_q[lk_set][hway]  : '0;
endmodule

// File: rtl/btb_offset_chk.sv
module btb_offset_chk #(
   parameter int unsigned OFF_W  = 4,
   parameter int unsigned IDX_W  = 9,
   parameter int unsigned TAG_W  = 9,
   parameter int unsigned TGT_W  = 32,
   parameter int unsigned KIND_W = 2,
   localparam int unsigned TAG_LSB = OFF_W + IDX_W,
   localparam int unsigned USE_W   = TAG_LSB + TAG_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lk_valid,
   input logic [USE_W-1:0]  lk_addr,
   input logic              up_valid,
   input logic [USE_W-1:0]  up_addr,
   input logic [TGT_W-1:0]  up_target,
   input logic [KIND_W-1:0] up_kind,
   input logic              bog_valid,
   input logic [IDX_W-1:0]  bog_set,
   input logic              rs_hit,
   input logic [TGT_W-1:0]  rs_target,
   input logic [KIND_W-1:0] rs_kind,
   input logic [OFF_W-1:0]  rs_offset
);
   logic armed;
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      armed && !$past(lk_valid) |-> !rs_hit && rs_target == '0 && rs_kind == '0 && rs_offset == '0); // R2

   AST_HIT_NOT_BELOW_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      armed && rs_hit |-> $past(lk_valid) && rs_offset >= $past(lk_addr[OFF_W-1:0])); // R4

   AST_CLEARED_SET_MISSES: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(lk_valid) && $past(bog_valid) && !$past(up_valid)
      && $past(lk_addr[TAG_LSB-1:OFF_W]) == $past(bog_set) |-> !rs_hit); // R8

   AST_UPDATE_BEFORE_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(lk_valid) && $past(up_valid) && $past(lk_addr) == $past(up_addr)
      |-> rs_hit && rs_target == $past(up_target) && rs_kind == $past(up_kind)
          && rs_offset == $past(up_addr[OFF_W-1:0])); // R9
endmodule

bind btb_offset_top btb_offset_chk #(
   .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(TGT_W), .KIND_W(KIND_W)
) chk_i (.*);

// File: tb/btb_offset_top_tb_top.sv
module btb_offset_top_tb_top;
   import btb_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0, up_valid = 1'b0, bog_valid = 1'b0;
   logic [21:0] lk_addr = '0, up_addr = '0;
   logic [31:0] up_target = '0;
   logic [1:0]  up_kind = '0;
   logic [8:0]  bog_set = '0;
   logic        rs_hit;
   logic [31:0] rs_target;
   logic [1:0]  rs_kind;
   logic [3:0]  rs_offset;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   btb_offset_top dut_i (.*);

   function automatic logic [21:0] mk(input logic [8:0] tag, input logic [8:0] set, input logic [3:0] off);
      return {tag, set, off};
   endfunction

   task automatic chk(input string req, input logic eh, input logic [31:0] et,
                      input logic [1:0] ek, input logic [3:0] eo);
      checks++;
      if (rs_hit !== eh || rs_target !== et || rs_kind !== ek || rs_offset !== eo) begin
         fails++;
         $display("FAIL %s: act hit=%0b tgt=%h kind=%0d off=%0d exp hit=%0b tgt=%h kind=%0d off=%0d",
                  req, rs_hit, rs_target, rs_kind, rs_offset, eh, et, ek, eo);
      end
   endtask

   task automatic upd(input logic [21:0] a, input logic [31:0] t, input logic [1:0] k);
      @(negedge clk);
      up_valid = 1'b1; up_addr = a; up_target = t; up_kind = k;
      @(negedge clk);
      up_valid = 1'b0;
   endtask

   task automatic look(input logic [21:0] a);
      @(negedge clk);
      lk_valid = 1'b1; lk_addr = a;
      @(negedge clk);
      lk_valid = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R2 idle after reset", 0, 0, 0, 0);
      look(mk(0, 0, 0));
      chk("R3 empty after reset", 0, 0, 0, 0);
   endtask

   task automatic t_basic();
      upd(mk(5, 10, 6), 32'hA000_1000, BK_CALL);
      look(mk(5, 10, 6));
      chk("R10 exact hit with kind", 1, 32'hA000_1000, BK_CALL, 6);
      @(negedge clk);
      chk("R2 no lookup no result", 0, 0, 0, 0);
      look(mk(5, 10, 0));
      chk("R4 fetch below branch hits", 1, 32'hA000_1000, BK_CALL, 6);
      look(mk(4, 10, 6));
      chk("R1 tag mismatch misses", 0, 0, 0, 0);
      look(mk(5, 11, 6));
      chk("R1 set mismatch misses", 0, 0, 0, 0);
      look(mk(5, 10, 7));
      chk("R4 branch below fetch misses", 0, 0, 0, 0);
   endtask

   task automatic t_select();
      upd(mk(3, 20, 12), 32'h0000_0C00, BK_COND);
      upd(mk(3, 20, 3),  32'h0000_0300, BK_DIRECT);
      upd(mk(3, 20, 9),  32'h0000_0900, BK_RETURN);
      look(mk(3, 20, 0));
      chk("R5 nearest from 0", 1, 32'h0000_0300, BK_DIRECT, 3);
      look(mk(3, 20, 4));
      chk("R5 nearest from 4", 1, 32'h0000_0900, BK_RETURN, 9);
      look(mk(3, 20, 10));
      chk("R5 nearest from 10", 1, 32'h0000_0C00, BK_COND, 12);
      look(mk(3, 20, 13));
      chk("R4 past all branches", 0, 0, 0, 0);
   endtask

   task automatic t_overwrite();
      upd(mk(7, 30, 5), 32'h1111_0005, BK_COND);
      upd(mk(7, 30, 6), 32'h1111_0006, BK_COND);
      upd(mk(7, 30, 7), 32'h1111_0007, BK_COND);
      upd(mk(7, 30, 5), 32'h2222_0005, BK_RETURN);
      look(mk(7, 30, 5));
      chk("R6 refreshed in place", 1, 32'h2222_0005, BK_RETURN, 5);
      look(mk(7, 30, 6));
      chk("R6 neighbour kept", 1, 32'h1111_0006, BK_COND, 6);
   endtask

   task automatic t_lru();
      for (int o = 0; o < 4; o++) upd(mk(1, 40, 4'(o)), 32'h4000_0000 + o, BK_DIRECT);
      look(mk(1, 40, 0));
      chk("R7 four fills use free ways", 1, 32'h4000_0000, BK_DIRECT, 0);
      upd(mk(1, 40, 9), 32'h4000_0009, BK_DIRECT);
      look(mk(1, 40, 1));
      chk("R7 LRU way evicted", 1, 32'h4000_0002, BK_DIRECT, 2);
      look(mk(1, 40, 0));
      chk("R7 recently hit way kept", 1, 32'h4000_0000, BK_DIRECT, 0);
   endtask

   task automatic t_bogus();
      upd(mk(2, 50, 4), 32'h5000_0004, BK_COND);
      upd(mk(2, 50, 8), 32'h5000_0008, BK_COND);
      upd(mk(2, 51, 4), 32'h5100_0004, BK_CALL);
      @(negedge clk);
      bog_valid = 1'b1; bog_set = 9'd50;
      @(negedge clk);
      bog_valid = 1'b0;
      look(mk(2, 50, 0));
      chk("R8 cleared set low", 0, 0, 0, 0);
      look(mk(2, 50, 5));
      chk("R8 cleared set high", 0, 0, 0, 0);
      look(mk(2, 51, 0));
      chk("R8 other set kept", 1, 32'h5100_0004, BK_CALL, 4);
   endtask

   task automatic t_same_cycle();
      upd(mk(6, 60, 2), 32'h6000_0001, BK_COND);
      @(negedge clk);
      up_valid = 1'b1; up_addr = mk(6, 60, 2); up_target = 32'h6000_0002; up_kind = BK_DIRECT;
      lk_valid = 1'b1; lk_addr = mk(6, 60, 2);
      @(negedge clk);
      up_valid = 1'b0; lk_valid = 1'b0;
      chk("R9 update seen by same-cycle lookup", 1, 32'h6000_0002, BK_DIRECT, 2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_select();
      t_overwrite();
      t_lru();
      t_bogus();
      t_same_cycle();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: act running exp finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule